// File: doc/BRIEF.md
# Fixed-Point Matrix-Vector Multiply-Accumulate Unit

This block multiplies a 3x3 matrix of signed 16-bit coefficients by a 3x1 vector of signed 16-bit elements. An optional signed 32-bit offset per row can be preloaded into the accumulator before the products are added. The unit has a single multiplier and completes one product per clock, so a full operation takes nine cycles. The rows are processed one after another, and within a row the columns are added in order.

The running sum is kept in a 44-bit two's-complement accumulator. After the first and the second addition of a row, the sum is checked against the 44-bit range and then folded back into it. The folding is deliberate, so intermediate overflow wraps instead of widening. The final sum of a row is also checked. It can then be scaled down by 2^12, and its low 32 bits form the row's wide result. That wide result is also saturated into a 16-bit value, held sign-extended in a 32-bit field. A mode bit moves the lower saturation bound up to zero.

A client drives the operands and the mode bits and pulses `start`. It then waits for the one-cycle `done` pulse and reads the three wide results, the three narrow results and the per-row flags.

Top module: `mtx_vec_mac`

## Requirements
- R1: A `start` pulse while idle captures all operands and mode bits, clears every overflow and saturation flag in the following cycle, and raises `busy`. A `start` pulse while `busy` is high is ignored, and later operand changes do not affect the running operation.
- R2: With `trans_en` set, row r's accumulator begins at its offset multiplied by 4096 (the offset occupies bits 43..12). With `trans_en` clear, it begins at zero.
- R3: Row r adds matrix element (r,0)·vec[0], then (r,1)·vec[1], then (r,2)·vec[2]. Matrix element (r,c) sits at `mat_i[(3r+c)*16 +: 16]`, vector element c at `vec_i[c*16 +: 16]` and offset r at `trans_i[r*32 +: 32]`. After the first and second additions the sum is reduced to 44-bit signed (wraparound). The third sum is not reduced.
- R4: Each of a row's three sums sets `ovf_pos[r]` if it exceeds 2^43−1 and `ovf_neg[r]` if it is below −2^43. Both flags are sticky for the rest of the operation.
- R5: With `frac_sel` set, the final row sum is shifted right arithmetically by 12 before its low 32 bits are taken. Otherwise the low 32 bits are taken unshifted. The result appears on `mac_o[r*32 +: 32]`.
- R6: `ir_o[r*32 +: 32]` holds the row's wide result clamped to −32768..32767, or to 0..32767 when `clamp_pos` is set, sign-extended to 32 bits.
- R7: `sat[r]` is set exactly when the clamp of R6 changed row r's value.
- R8: `busy` stays high for exactly nine cycles. Row r's results and `sat[r]` update on the (3r+3)-th busy edge. `done` is a one-cycle pulse in the cycle after `busy` falls.
- R9: While idle, all results hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured only while idle) |
| trans_en | input | 1 | Preload per-row offset times 4096 |
| frac_sel | input | 1 | Arithmetic shift right by 12 before truncation |
| clamp_pos | input | 1 | Narrow result lower bound is 0 instead of −32768 |
| mat_i | input | 144 | Matrix, element (r,c) at bits (3r+c)*16 |
| vec_i | input | 48 | Vector, element c at bits c*16 |
| trans_i | input | 96 | Per-row offsets, row r at bits r*32 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mac_o | output | 96 | Wide 32-bit results, row r at bits r*32 |
| ir_o | output | 96 | Saturated results, sign-extended to 32 bits |
| ovf_pos | output | 3 | Per-row positive 44-bit overflow |
| ovf_neg | output | 3 | Per-row negative 44-bit overflow |
| sat | output | 3 | Per-row narrow-result saturation |

## Verification
The accumulator is shared by all rows. A fault in its wrap width, in the operand selected for a step, or in the preload shows up in the next row result on `mac_o`, at most three cycles after the faulty step. The same fault often shows in an overflow flag within one cycle. Wraparound is forced separately at the first, second and third addition, in both directions. An error in the wrap point therefore shows up as a wrong flag set at a specific step and a wrong wide result at that row's end. A wrong step counter breaks the nine-cycle `busy` window and the timing of `done` at once. Because the bench compares every output on every clock, any divergence is reported in the cycle it appears.

// File: rtl/mvm_pkg.sv
package mvm_pkg;
    localparam int COEF_W  = 16;
    localparam int TR_W    = 32;
    localparam int FRAC_SH = 12;
    localparam int ACC_W   = TR_W + FRAC_SH;
    localparam int SUM_W   = ACC_W + 1;
    localparam int PROD_W  = 2 * COEF_W;
    localparam int REG_W   = 32;
    localparam int IR_W    = 16;
    localparam int LANES   = 3;
    localparam int ELEMS   = LANES * LANES;
    localparam int IDX_W   = $clog2(LANES);

    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [SUM_W-1:0]  sum_t;
    typedef logic signed [TR_W-1:0]   trans_t;
    typedef logic signed [REG_W-1:0]  word_t;

    typedef enum logic {PH_IDLE = 1'b0, PH_RUN = 1'b1} phase_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } ovf_t;

    typedef struct packed {
        word_t val;
        logic  hit;
    } clamp_t;

    typedef struct packed {
        logic trans_en;
        logic frac_sel;
        logic clamp_pos;
    } mode_t;

    typedef struct packed {
        word_t mac;
        word_t ir;
        logic  pos;
        logic  neg;
        logic  sat;
    } lane_t;

    // Out of the 44-bit signed range when the top two bits of the 45-bit sum differ
    function automatic ovf_t range_check(sum_t s);
        ovf_t o;
        o.pos = ~s[SUM_W-1] & s[ACC_W-1];
        o.neg = s[SUM_W-1] & ~s[ACC_W-1];
        return o;
    endfunction

    function automatic acc_t wrap_acc(sum_t s);
        return acc_t'(s[ACC_W-1:0]);
    endfunction

    function automatic acc_t preload(trans_t t, logic en);
        return en ? acc_t'({t, {FRAC_SH{1'b0}}}) : '0;
    endfunction

    function automatic word_t scale_out(sum_t s, logic frac);
        sum_t t;
        t = frac ? (s >>> FRAC_SH) : s;
        return word_t'(t[REG_W-1:0]);
    endfunction

    function automatic clamp_t sat_narrow(word_t v, logic pos_only);
        word_t  hi;
        word_t  lo;
        clamp_t c;
        hi = word_t'((1 << (IR_W - 1)) - 1);
        lo = pos_only ? '0 : ~hi;
        if (v > hi) begin
            c.val = hi;
            c.hit = 1'b1;
        end else if (v < lo) begin
            c.val = lo;
            c.hit = 1'b1;
        end else begin
            c.val = v;
            c.hit = 1'b0;
        end
        return c;
    endfunction
endpackage

// File: rtl/mvm_ctrl.sv
module mvm_ctrl
    import mvm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic             launch,
    output logic             busy,
    output logic             row_end,
    output logic             done,
    output logic [IDX_W-1:0] row_idx,
    output logic [IDX_W-1:0] col_idx
);
    phase_e           ph_q;
    logic [IDX_W-1:0] row_q;
    logic [IDX_W-1:0] col_q;
    logic             last_col;
    logic             last_step;

    assign busy      = (ph_q == PH_RUN);
    assign launch    = start && (ph_q == PH_IDLE);
    assign last_col  = (col_q == IDX_W'(LANES - 1));
    assign row_end   = busy && last_col;
    assign last_step = row_end && (row_q == IDX_W'(LANES - 1));
    assign row_idx   = row_q;
    assign col_idx   = col_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= PH_IDLE;
            row_q <= '0;
            col_q <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (launch) begin
                ph_q  <= PH_RUN;
                row_q <= '0;
                col_q <= '0;
            end else if (busy) begin
                if (last_step) begin
                    ph_q  <= PH_IDLE;
                    row_q <= '0;
                    col_q <= '0;
                    done  <= 1'b1;
                end else if (last_col) begin
                    col_q <= '0;
                    row_q <= row_q + 1'b1;
                end else begin
                    col_q <= col_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mvm_acc.sv
module mvm_acc
    import mvm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  busy,
    input  logic  first,
    input  coef_t a_coef,
    input  coef_t b_coef,
    input  acc_t  init_val,
    output sum_t  sum,
    output ovf_t  ovf
);
    acc_t  acc_q;
    acc_t  base;
    prod_t prod;

    always_comb begin
        prod = a_coef * b_coef;
        base = first ? init_val : acc_q;
        sum  = sum_t'(base) + sum_t'(prod);
        ovf  = range_check(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (busy) begin
            acc_q <= wrap_acc(sum);
        end
    end
endmodule

// File: rtl/mvm_irsat.sv
module mvm_irsat
    import mvm_pkg::*;
(
    input  word_t mac_val,
    input  logic  pos_only,
    output word_t ir_val,
    output logic  hit
);
    clamp_t c;

    always_comb begin
        c      = sat_narrow(mac_val, pos_only);
        ir_val = c.val;
        hit    = c.hit;
    end
endmodule

// File: rtl/mtx_vec_mac.sv
module mtx_vec_mac
    import mvm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     trans_en,
    input  logic                     frac_sel,
    input  logic                     clamp_pos,
    input  logic [ELEMS*COEF_W-1:0]  mat_i,
    input  logic [LANES*COEF_W-1:0]  vec_i,
    input  logic [LANES*TR_W-1:0]    trans_i,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*REG_W-1:0]   mac_o,
    output logic [LANES*REG_W-1:0]   ir_o,
    output logic [LANES-1:0]         ovf_pos,
    output logic [LANES-1:0]         ovf_neg,
    output logic [LANES-1:0]         sat
);
    logic             launch;
    logic             row_end;
    logic [IDX_W-1:0] row_idx;
    logic [IDX_W-1:0] col_idx;

    coef_t  mat_q [ELEMS];
    coef_t  vec_q [LANES];
    trans_t tr_q  [LANES];
    mode_t  mode_q;

    coef_t  a_sel;
    coef_t  b_sel;
    acc_t   init_sel;
    sum_t   acc_sum;
    ovf_t   step_ovf;
    word_t  mac_val;
    word_t  ir_val;
    logic   ir_hit;
    lane_t  lane_q [LANES];

    mvm_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .launch  (launch),
        .busy    (busy),
        .row_end (row_end),
        .done    (done),
        .row_idx (row_idx),
        .col_idx (col_idx)
    );

    // Operand capture on a honoured start
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < ELEMS; k++) mat_q[k] <= '0;
            for (int k = 0; k < LANES; k++) begin
                vec_q[k] <= '0;
                tr_q[k]  <= '0;
            end
            mode_q <= '0;
        end else if (launch) begin
            for (int k = 0; k < ELEMS; k++) mat_q[k] <= coef_t'(mat_i[k*COEF_W +: COEF_W]);
            for (int k = 0; k < LANES; k++) begin
                vec_q[k] <= coef_t'(vec_i[k*COEF_W +: COEF_W]);
                tr_q[k]  <= trans_t'(trans_i[k*TR_W +: TR_W]);
            end
            mode_q <= '{trans_en: trans_en, frac_sel: frac_sel, clamp_pos: clamp_pos};
        end
    end

    // Operand selection for the current step
    always_comb begin
        int el;
        el       = int'(row_idx) * LANES + int'(col_idx);
        a_sel    = '0;
        b_sel    = '0;
        init_sel = '0;
        for (int k = 0; k < ELEMS; k++) begin
            if (k == el) a_sel = mat_q[k];
        end
        for (int k = 0; k < LANES; k++) begin
            if (k == int'(col_idx)) b_sel = vec_q[k];
            if (k == int'(row_idx)) init_sel = preload(tr_q[k], mode_q.trans_en);
        end
    end

    mvm_acc u_acc (
        .clk      (clk),
        .rst      (rst),
        .busy     (busy),
        .first    (col_idx == '0),
        .a_coef   (a_sel),
        .b_coef   (b_sel),
        .init_val (init_sel),
        .sum      (acc_sum),
        .ovf      (step_ovf)
    );

    assign mac_val = scale_out(acc_sum, mode_q.frac_sel);

    mvm_irsat u_sat (
        .mac_val  (mac_val),
        .pos_only (mode_q.clamp_pos),
        .ir_val   (ir_val),
        .hit      (ir_hit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic mine;
        assign mine = busy && (row_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                lane_q[g] <= '0;
            end else if (launch) begin
                lane_q[g].pos <= 1'b0;
                lane_q[g].neg <= 1'b0;
                lane_q[g].sat <= 1'b0;
            end else if (mine) begin
                lane_q[g].pos <= lane_q[g].pos | step_ovf.pos;
                lane_q[g].neg <= lane_q[g].neg | step_ovf.neg;
                if (row_end) begin
                    lane_q[g].mac <= mac_val;
                    lane_q[g].ir  <= ir_val;
                    lane_q[g].sat <= ir_hit;
                end
            end
        end

        assign mac_o[g*REG_W +: REG_W] = lane_q[g].mac;
        assign ir_o[g*REG_W +: REG_W]  = lane_q[g].ir;
        assign ovf_pos[g]              = lane_q[g].pos;
        assign ovf_neg[g]              = lane_q[g].neg;
        assign sat[g]                  = lane_q[g].sat;
    end
endmodule

// File: rtl/mvm_chk.sv
module mvm_chk
    import mvm_pkg::*;
(
    input logic                   clk,
    input logic                   rst,
    input logic                   start,
    input logic                   busy,
    input logic                   done,
    input logic [LANES*REG_W-1:0] mac_o,
    input logic [LANES*REG_W-1:0] ir_o,
    input logic [LANES-1:0]       ovf_pos,
    input logic [LANES-1:0]       ovf_neg,
    input logic [LANES-1:0]       sat
);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_end_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_flags_clear_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (ovf_pos == '0 && ovf_neg == '0 && sat == '0));

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        busy |=> (((ovf_pos & $past(ovf_pos)) == $past(ovf_pos)) &&
                  ((ovf_neg & $past(ovf_neg)) == $past(ovf_neg))));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(mac_o) && $stable(ir_o)));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        assert_ir_ext_R6: assert property (@(posedge clk) disable iff (rst)
            ir_o[g*REG_W+IR_W +: (REG_W-IR_W)] == {(REG_W-IR_W){ir_o[g*REG_W+IR_W-1]}});
    end
endmodule

bind mtx_vec_mac mvm_chk u_chk (.*);

// File: tb/tb_mtx_vec_mac.sv
module tb_mtx_vec_mac;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, start, t_en, f_sel, c_pos;
    logic signed [15:0] b_m [9];
    logic signed [15:0] b_v [3];
    logic signed [31:0] b_t [3];
    logic [143:0] mat_i;
    logic [47:0]  vec_i;
    logic [95:0]  trans_i;
    logic         busy, done;
    logic [95:0]  mac_o, ir_o;
    logic [2:0]   ovf_pos, ovf_neg, sat;

    always_comb begin
        for (int k = 0; k < 9; k++) mat_i[k*16 +: 16] = b_m[k];
        for (int k = 0; k < 3; k++) begin
            vec_i[k*16 +: 16]   = b_v[k];
            trans_i[k*32 +: 32] = b_t[k];
        end
    end

    mtx_vec_mac dut (
        .clk(clk), .rst(rst), .start(start), .trans_en(t_en), .frac_sel(f_sel),
        .clamp_pos(c_pos), .mat_i(mat_i), .vec_i(vec_i), .trans_i(trans_i),
        .busy(busy), .done(done), .mac_o(mac_o), .ir_o(ir_o),
        .ovf_pos(ovf_pos), .ovf_neg(ovf_neg), .sat(sat)
    );

    int    checks = 0;
    int    fails  = 0;
    string scn    = "R9 reset";
    bit    ended  = 0;

    // ---------------- behavioural reference ----------------
    logic [31:0] e_mac [3];
    logic [31:0] e_ir  [3];
    logic [2:0]  e_pos, e_neg, e_sat;
    logic        e_busy, e_done;
    int          e_cnt;
    logic [31:0] p_mac [3];
    logic [31:0] p_ir  [3];
    logic        p_sat [3];
    logic        p_pos [9];
    logic        p_neg [9];

    function automatic void ref_row(int r);
        longint s, sh, mv, lo;
        s = t_en ? (longint'(b_t[r]) <<< 12) : 64'sd0;
        for (int c = 0; c < 3; c++) begin
            s = s + longint'(b_m[r*3+c]) * longint'(b_v[c]);
            p_pos[r*3+c] = (s > ((64'sd1 <<< 43) - 1));
            p_neg[r*3+c] = (s < -(64'sd1 <<< 43));
            if (c < 2) s = (s <<< 20) >>> 20;
        end
        sh = f_sel ? (s >>> 12) : s;
        p_mac[r] = sh[31:0];
        mv = longint'($signed(sh[31:0]));
        lo = c_pos ? 64'sd0 : -64'sd32768;
        p_sat[r] = 1'b1;
        if (mv > 32767)   p_ir[r] = 32'd32767;
        else if (mv < lo) p_ir[r] = lo[31:0];
        else begin
            p_ir[r]  = mv[31:0];
            p_sat[r] = 1'b0;
        end
    endfunction

    always @(posedge clk) begin
        int r;
        if (rst) begin
            for (int k = 0; k < 3; k++) begin
                e_mac[k] <= '0;
                e_ir[k]  <= '0;
            end
            e_pos <= '0; e_neg <= '0; e_sat <= '0;
            e_busy <= 1'b0; e_done <= 1'b0; e_cnt <= 0;
        end else begin
            e_done <= 1'b0;
            if (start && !e_busy) begin
                for (int k = 0; k < 3; k++) ref_row(k);
                e_busy <= 1'b1; e_cnt <= 0;
                e_pos <= '0; e_neg <= '0; e_sat <= '0;
            end else if (e_busy) begin
                r = e_cnt / 3;
                e_pos[r] <= e_pos[r] | p_pos[e_cnt];
                e_neg[r] <= e_neg[r] | p_neg[e_cnt];
                if (e_cnt % 3 == 2) begin
                    e_mac[r] <= p_mac[r];
                    e_ir[r]  <= p_ir[r];
                    e_sat[r] <= p_sat[r];
                end
                if (e_cnt == 8) begin
                    e_busy <= 1'b0;
                    e_done <= 1'b1;
                end
                e_cnt <= e_cnt + 1;
            end
        end
    end

    // ---------------- comparison on every clock ----------------
    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s] t=%0t actual=%h expected=%h", req, scn, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk("R8 busy", 32'(busy), 32'(e_busy));
            chk("R8 done", 32'(done), 32'(e_done));
            chk("R4 ovf_pos", 32'(ovf_pos), 32'(e_pos));
            chk("R4 ovf_neg", 32'(ovf_neg), 32'(e_neg));
            chk("R7 sat", 32'(sat), 32'(e_sat));
            for (int r = 0; r < 3; r++) begin
                chk("R5 mac", mac_o[r*32 +: 32], e_mac[r]);
                chk("R6 ir", ir_o[r*32 +: 32], e_ir[r]);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic set_mat(int a0, int a1, int a2, int a3, int a4, int a5,
                           int a6, int a7, int a8);
        b_m[0] = 16'(a0); b_m[1] = 16'(a1); b_m[2] = 16'(a2);
        b_m[3] = 16'(a3); b_m[4] = 16'(a4); b_m[5] = 16'(a5);
        b_m[6] = 16'(a6); b_m[7] = 16'(a7); b_m[8] = 16'(a8);
    endtask

    task automatic set_vt(int v0, int v1, int v2, int t0, int t1, int t2);
        b_v[0] = 16'(v0); b_v[1] = 16'(v1); b_v[2] = 16'(v2);
        b_t[0] = t0; b_t[1] = t1; b_t[2] = t2;
    endtask

    task automatic run_op(string s, bit te, bit fs, bit cp);
        scn = s; t_en = te; f_sel = fs; c_pos = cp;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (11) @(negedge clk);
    endtask

    task automatic finish_all();
        ended = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R8 run did not complete actual=hung expected=finished");
        finish_all();
    end

    int unsigned seed = 32'h1234_5678;
    function automatic int rnd16();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[31:16]));
    endfunction

    initial begin
        rst = 1'b1; start = 1'b0; t_en = 0; f_sel = 0; c_pos = 0;
        set_mat(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_vt(0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        set_mat(1, 2, 3, 4, 5, 6, 7, 8, 9);
        set_vt(2, -3, 4, 0, 0, 0);
        run_op("R3 column order", 0, 0, 0);

        set_vt(2, -3, 4, 100, -200, 7);
        run_op("R2 translation", 1, 0, 0);

        set_mat(-300, 17, 5, 1000, -1000, 9, 0, 0, -1);
        set_vt(123, 456, 789, -5, 70000, -1);
        run_op("R5 shifted result", 1, 1, 0);

        set_mat(-100, 0, 0, 0, 40, 0, 0, 0, 1000);
        set_vt(50, 50, 50, 0, 0, 0);
        run_op("R6 positive-only clamp", 0, 0, 1);

        set_mat(30000, 0, 0, -30000, 0, 0, 3, 0, 0);
        set_vt(30000, 0, 0, 0, 0, 0);
        run_op("R7 saturation both ways", 0, 0, 0);

        set_mat(32767, 0, 0, 0, 32767, 0, 0, 0, 32767);
        set_vt(32767, 32767, 32767, 32'h7fff_ffff, 32'h7fff_ffff, 32'h7fff_ffff);
        run_op("R3 positive wrap per step", 1, 0, 0);
        run_op("R3 positive wrap shifted", 1, 1, 0);

        set_mat(-32768, 0, 0, 0, -32768, 0, 0, 0, -32768);
        set_vt(32767, 32767, 32767, 32'h8000_0000, 32'h8000_0000, 32'h8000_0000);
        run_op("R3 negative wrap per step", 1, 0, 0);
        run_op("R4 negative wrap shifted clamp", 1, 1, 1);

        // R1: start during an operation is ignored, operand changes have no effect
        set_mat(11, 22, 33, -44, 55, -66, 77, -88, 99);
        set_vt(1000, -2000, 3000, 5, 6, 7);
        scn = "R1 start while busy"; t_en = 1; f_sel = 0; c_pos = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        set_mat(-1, -1, -1, -1, -1, -1, -1, -1, -1);
        set_vt(9, 9, 9, 1, 1, 1);
        f_sel = 1; c_pos = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (9) @(negedge clk);

        for (int n = 0; n < 16; n++) begin
            set_mat(rnd16(), rnd16(), rnd16(), rnd16(), rnd16(), rnd16(),
                    rnd16(), rnd16(), rnd16());
            set_vt(rnd16(), rnd16(), rnd16(),
                   (rnd16() <<< 16) | (rnd16() & 16'hffff),
                   (rnd16() <<< 16) | (rnd16() & 16'hffff),
                   (rnd16() <<< 16) | (rnd16() & 16'hffff));
            run_op("R5 random operands", n[0], n[1], n[2]);
        end

        scn = "R9 idle hold";
        for (int n = 0; n < 6; n++) begin
            set_mat(n, n, n, n, n, n, n, n, n);
            set_vt(n, n, n, n, n, n);
            t_en = n[0]; f_sel = n[1]; c_pos = n[0];
            @(negedge clk);
        end

        finish_all();
    end
endmodule